// File: doc/BRIEF.md
# Shared Interrupt Pending State Tracker

This block holds the per-line state of the shared interrupts in an interrupt distributor. For each interrupt it keeps a pending bit, an active bit, an enable bit, a trigger mode (level or edge) and a marker that records whether the current pending state came from a software write. The ID space is `NUM_IRQ` wide. IDs 0 to 31 belong to the private (software-generated and per-CPU) range, so only IDs 32 to `NUM_IRQ-1` hold state.

Pending state comes from two places. Hardware sends single-cycle assert and deassert requests carrying an interrupt ID. Software writes set-pending and clear-pending words, each made of a word index and a 32-bit mask. The CPU side sends an activate request when it acknowledges an interrupt. A level-sensitive interrupt that software made pending behaves like an edge-triggered one when software clears it and when it is activated. A later hardware assertion removes that software marking. Arbitration, security grouping and bus decode are handled elsewhere.

Top module: `irq_pend_tracker`

## Requirements
- R1: After a synchronous reset, every line is level-sensitive, disabled, not pending and not active, and `err_o` is 0.
- R2: A set-pending write with word index w and mask bit b set makes ID 32*w+b pending. Mask bits that map to IDs below 32 are ignored.
- R3: A hardware assert of a valid ID makes it pending and removes the software marking. After that, a clear-pending write to a level-sensitive line leaves it pending.
- R4: A clear-pending write clears a line's pending bit only when the line is edge-configured or was last made pending by software. Otherwise the write has no effect.
- R5: An activate request always sets the line's active bit. It clears the pending bit only when the line is edge-configured or software-pended, so a hardware-pended level line stays both pending and active.
- R6: A hardware deassert clears pending only on a level-configured line. An edge-configured line stays pending.
- R7: An assert, deassert, activate or configuration request whose ID is below 32 or at or above `NUM_IRQ` changes no line state. It sets `err_o`, which then stays at 1 until reset.
- R8: When a set source (hardware assert or set-pending write) and a clear source hit the same line in one cycle, the line ends up pending.
- R9: A configuration write sets one line's trigger mode (`cfg_edge` 1 = edge, 0 = level) and its enable bit. The enable bit is shown on `enabled_o`.
- R10: Bit i of `pending_o`, `active_o` and `enabled_o` is the state of ID i. Each output is registered and shows the effect of an input cycle right after the next rising clock edge. Bits 0 to 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_set_vld | input | 1 | Hardware assert request |
| hw_set_id | input | IDW | ID for hardware assert |
| hw_clr_vld | input | 1 | Hardware deassert request |
| hw_clr_id | input | IDW | ID for hardware deassert |
| swset_vld | input | 1 | Set-pending word write |
| swset_word | input | WW | Word index of the set-pending write |
| swset_mask | input | 32 | Bit mask of the set-pending write |
| swclr_vld | input | 1 | Clear-pending word write |
| swclr_word | input | WW | Word index of the clear-pending write |
| swclr_mask | input | 32 | Bit mask of the clear-pending write |
| act_vld | input | 1 | Activate request from the CPU side |
| act_id | input | IDW | ID to activate |
| cfg_vld | input | 1 | Configuration write |
| cfg_id | input | IDW | ID to configure |
| cfg_edge | input | 1 | Trigger mode: 1 edge, 0 level |
| cfg_en | input | 1 | Enable bit value |
| pending_o | output | NUM_IRQ | Pending bit per ID |
| active_o | output | NUM_IRQ | Active bit per ID |
| enabled_o | output | NUM_IRQ | Enable bit per ID |
| err_o | output | 1 | Sticky invalid-ID flag |

## Verification
Every result of this block is due exactly one clock after the input cycle. This covers pending, active and enable changes and the error flag, because each is a single register updated from that cycle's requests. The driver applies one cycle of requests on the falling edge and pushes the expected vectors into a queue. The monitor pops and compares them one time step after the following rising edge, so each comparison lands in the cycle the result first appears. Same-cycle conflicts are driven as one cycle, so the precedence rule is checked where it applies.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int SHARED_BASE = 32;
  localparam int WORD_BITS   = 32;

  typedef struct packed {
    logic hw_set;
    logic hw_clr;
    logic sw_set;
    logic sw_clr;
    logic act;
    logic cfg_we;
  } line_req_t;
endpackage

// File: rtl/irq_id_decode.sv
module irq_id_decode #(
  parameter int NUM_IRQ = 64,
  parameter int IDW     = $clog2(NUM_IRQ),
  localparam int NSH    = NUM_IRQ - irq_trk_pkg::SHARED_BASE
) (
  input  logic           vld,
  input  logic [IDW-1:0] id,
  output logic [NSH-1:0] hit,
  output logic           bad
);
  logic [31:0] idv;
  assign idv = 32'(id);

  for (genvar j = 0; j < NSH; j++) begin : g_hit
    localparam int LINE_ID = j + irq_trk_pkg::SHARED_BASE;
    assign hit[j] = vld && (idv == 32'(LINE_ID));
  end

  assign bad = vld && ((idv < 32'(irq_trk_pkg::SHARED_BASE)) || (idv >= 32'(NUM_IRQ)));
endmodule

// File: rtl/irq_mask_expand.sv
module irq_mask_expand #(
  parameter int NUM_IRQ = 64,
  parameter int WW      = $clog2(NUM_IRQ / 32),
  localparam int NSH    = NUM_IRQ - irq_trk_pkg::SHARED_BASE
) (
  input  logic           vld,
  input  logic [WW-1:0]  word,
  input  logic [31:0]    mask,
  output logic [NSH-1:0] hit
);
  for (genvar j = 0; j < NSH; j++) begin : g_bit
    localparam int LINE_ID = j + irq_trk_pkg::SHARED_BASE;
    localparam int WIDX    = LINE_ID / irq_trk_pkg::WORD_BITS;
    localparam int BIDX    = LINE_ID % irq_trk_pkg::WORD_BITS;
    assign hit[j] = vld && (word == WW'(WIDX)) && mask[BIDX];
  end
endmodule

// File: rtl/irq_line_state.sv
module irq_line_state
  import irq_trk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_req_t req,
  input  logic      cfg_edge,
  input  logic      cfg_en,
  output logic      pend,
  output logic      active,
  output logic      enabled
);
  logic pend_q, act_q, en_q, edge_q, swmark_q;
  logic pend_d, swmark_d;
  logic as_edge;

  // Edge treatment for clear and activate: edge mode or software origin.
  assign as_edge = edge_q | swmark_q;

  always_comb begin
    pend_d = pend_q;
    if (req.hw_clr && !edge_q) pend_d = 1'b0;
    if (req.sw_clr && as_edge) pend_d = 1'b0;
    if (req.act    && as_edge) pend_d = 1'b0;
    if (req.sw_set)            pend_d = 1'b1;
    if (req.hw_set)            pend_d = 1'b1;

    if (req.hw_set)      swmark_d = 1'b0;
    else if (req.sw_set) swmark_d = 1'b1;
    else                 swmark_d = swmark_q;
    swmark_d = swmark_d & pend_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      act_q    <= 1'b0;
      en_q     <= 1'b0;
      edge_q   <= 1'b0;
      swmark_q <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      swmark_q <= swmark_d;
      if (req.act) act_q <= 1'b1;
      if (req.cfg_we) begin
        edge_q <= cfg_edge;
        en_q   <= cfg_en;
      end
    end
  end

  assign pend    = pend_q;
  assign active  = act_q;
  assign enabled = en_q;

  AST_HW_SET_PENDS: assert property (@(posedge clk) disable iff (rst)
    req.hw_set |=> pend_q); // R3
  AST_LEVEL_CLR_NOP: assert property (@(posedge clk) disable iff (rst)
    (req.sw_clr && !as_edge && !req.hw_clr && !req.sw_set && !req.hw_set) |=> $stable(pend_q)); // R4
  AST_ACT_SETS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    req.act |=> act_q); // R5
  AST_ACT_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req.act && pend_q && !as_edge && !req.hw_clr) |=> pend_q); // R5
  AST_EDGE_DEASSERT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req.hw_clr && edge_q && pend_q && !req.sw_clr && !req.act) |=> pend_q); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ((req.hw_set || req.sw_set) && (req.sw_clr || req.hw_clr || req.act)) |=> pend_q); // R8
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irq_trk_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int IDW     = $clog2(NUM_IRQ),
  parameter int WW      = $clog2(NUM_IRQ / 32)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hw_set_vld,
  input  logic [IDW-1:0]     hw_set_id,
  input  logic               hw_clr_vld,
  input  logic [IDW-1:0]     hw_clr_id,
  input  logic               swset_vld,
  input  logic [WW-1:0]      swset_word,
  input  logic [31:0]        swset_mask,
  input  logic               swclr_vld,
  input  logic [WW-1:0]      swclr_word,
  input  logic [31:0]        swclr_mask,
  input  logic               act_vld,
  input  logic [IDW-1:0]     act_id,
  input  logic               cfg_vld,
  input  logic [IDW-1:0]     cfg_id,
  input  logic               cfg_edge,
  input  logic               cfg_en,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic [NUM_IRQ-1:0] active_o,
  output logic [NUM_IRQ-1:0] enabled_o,
  output logic               err_o
);
  localparam int NSH = NUM_IRQ - SHARED_BASE;

  logic [NSH-1:0] hs_hit, hc_hit, ss_hit, sc_hit, ac_hit, cf_hit;
  logic           hs_bad, hc_bad, ac_bad, cf_bad, any_bad;
  logic [NSH-1:0] pend_sh, act_sh, en_sh;
  logic           err_q;

  irq_id_decode #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_dec_hs (
    .vld(hw_set_vld), .id(hw_set_id), .hit(hs_hit), .bad(hs_bad));
  irq_id_decode #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_dec_hc (
    .vld(hw_clr_vld), .id(hw_clr_id), .hit(hc_hit), .bad(hc_bad));
  irq_id_decode #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_dec_ac (
    .vld(act_vld), .id(act_id), .hit(ac_hit), .bad(ac_bad));
  irq_id_decode #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_dec_cf (
    .vld(cfg_vld), .id(cfg_id), .hit(cf_hit), .bad(cf_bad));

  irq_mask_expand #(.NUM_IRQ(NUM_IRQ), .WW(WW)) u_exp_set (
    .vld(swset_vld), .word(swset_word), .mask(swset_mask), .hit(ss_hit));
  irq_mask_expand #(.NUM_IRQ(NUM_IRQ), .WW(WW)) u_exp_clr (
    .vld(swclr_vld), .word(swclr_word), .mask(swclr_mask), .hit(sc_hit));

  for (genvar j = 0; j < NSH; j++) begin : g_line
    line_req_t rq;
    assign rq.hw_set = hs_hit[j];
    assign rq.hw_clr = hc_hit[j];
    assign rq.sw_set = ss_hit[j];
    assign rq.sw_clr = sc_hit[j];
    assign rq.act    = ac_hit[j];
    assign rq.cfg_we = cf_hit[j];

    irq_line_state u_line (
      .clk(clk), .rst(rst), .req(rq),
      .cfg_edge(cfg_edge), .cfg_en(cfg_en),
      .pend(pend_sh[j]), .active(act_sh[j]), .enabled(en_sh[j]));
  end

  assign any_bad = hs_bad | hc_bad | ac_bad | cf_bad;

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_q | any_bad;
  end

  assign pending_o = {pend_sh, {SHARED_BASE{1'b0}}};
  assign active_o  = {act_sh,  {SHARED_BASE{1'b0}}};
  assign enabled_o = {en_sh,   {SHARED_BASE{1'b0}}};
  assign err_o     = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R7
  AST_BAD_ID_FLAGS: assert property (@(posedge clk) disable iff (rst)
    any_bad |=> err_q); // R7
  AST_PRIV_RANGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pending_o[SHARED_BASE-1:0] == '0) && (active_o[SHARED_BASE-1:0] == '0)); // R10
endmodule

// File: tb/irq_pend_tracker_tb.sv
module irq_pend_tracker_tb;
  localparam int N   = 64;
  localparam int IDW = 6;
  localparam int WW  = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_set_vld, hw_clr_vld, swset_vld, swclr_vld, act_vld, cfg_vld;
  logic [IDW-1:0] hw_set_id, hw_clr_id, act_id, cfg_id;
  logic [WW-1:0]  swset_word, swclr_word;
  logic [31:0]    swset_mask, swclr_mask;
  logic cfg_edge, cfg_en;
  logic [N-1:0] pending_o, active_o, enabled_o;
  logic err_o;

  always #2 clk = ~clk; // 250 MHz

  irq_pend_tracker #(.NUM_IRQ(N), .IDW(IDW), .WW(WW)) u_dut (.*);

  // Reference state derived from the requirements
  logic [N-1:0] m_pend = '0, m_act = '0, m_en = '0, m_edge = '0, m_mark = '0;
  logic m_err = 1'b0;

  logic [N-1:0] q_p[$], q_a[$], q_e[$];
  logic q_err[$];
  string q_tag[$];
  int total = 0, bad = 0;
  bit done = 0;

  task automatic idle_in();
    hw_set_vld = 0; hw_clr_vld = 0; swset_vld = 0; swclr_vld = 0;
    act_vld = 0; cfg_vld = 0;
    hw_set_id = '0; hw_clr_id = '0; act_id = '0; cfg_id = '0;
    swset_word = '0; swclr_word = '0; swset_mask = '0; swclr_mask = '0;
    cfg_edge = 0; cfg_en = 0;
  endtask

  function automatic bit bad_id(int id);
    return (id < 32) || (id >= N);
  endfunction

  task automatic t_cfg(int id, bit e, bit en);
    cfg_vld = 1; cfg_id = IDW'(id); cfg_edge = e; cfg_en = en;
    if (bad_id(id)) m_err = 1; else begin m_edge[id] = e; m_en[id] = en; end
  endtask

  task automatic t_set(int w, logic [31:0] m);
    swset_vld = 1; swset_word = WW'(w); swset_mask = m;
    for (int b = 0; b < 32; b++) begin
      int id = w * 32 + b;
      if (m[b] && id >= 32) begin m_pend[id] = 1; m_mark[id] = 1; end
    end
  endtask

  task automatic t_clr(int w, logic [31:0] m);
    swclr_vld = 1; swclr_word = WW'(w); swclr_mask = m;
    for (int b = 0; b < 32; b++) begin
      int id = w * 32 + b;
      if (m[b] && id >= 32 && (m_edge[id] || m_mark[id])) m_pend[id] = 0;
    end
  endtask

  task automatic t_hw(int id);
    hw_set_vld = 1; hw_set_id = IDW'(id);
    if (bad_id(id)) m_err = 1; else begin m_pend[id] = 1; m_mark[id] = 0; end
  endtask

  task automatic t_deas(int id);
    hw_clr_vld = 1; hw_clr_id = IDW'(id);
    if (bad_id(id)) m_err = 1; else if (!m_edge[id]) m_pend[id] = 0;
  endtask

  task automatic t_act(int id);
    act_vld = 1; act_id = IDW'(id);
    if (bad_id(id)) m_err = 1;
    else begin
      if (m_edge[id] || m_mark[id]) m_pend[id] = 0;
      m_act[id] = 1;
    end
  endtask

  // Push the expected result of this cycle's requests, run one cycle, release.
  task automatic go(string tag);
    q_p.push_back(m_pend); q_a.push_back(m_act); q_e.push_back(m_en);
    q_err.push_back(m_err); q_tag.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    idle_in();
  endtask

  // Monitor: results are due one edge after the input cycle.
  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0) begin
      logic [N-1:0] ep, ea, ee;
      logic er;
      string tg;
      ep = q_p.pop_front(); ea = q_a.pop_front(); ee = q_e.pop_front();
      er = q_err.pop_front(); tg = q_tag.pop_front();
      total++;
      if (pending_o !== ep || active_o !== ea || enabled_o !== ee || err_o !== er) begin
        bad++;
        $display("FAIL %s: pend=%h/%h act=%h/%h en=%h/%h err=%b/%b (actual/expected)",
                 tg, pending_o, ep, active_o, ea, enabled_o, ee, err_o, er);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_in();
    repeat (3) @(negedge clk);
    rst = 0;
    go("R1 reset state");
    go("R1 idle hold");

    t_cfg(40, 1, 1); go("R9 cfg 40 edge enabled");
    t_cfg(41, 0, 1); go("R9 cfg 41 level enabled");

    t_set(0, 32'hFFFF_FFFF); go("R2 word0 bits ignored");
    t_set(1, 32'h0000_0300); go("R2 set 40 and 41");
    t_clr(1, 32'h0000_0300); go("R4 clear edge 40 and sw-pended level 41");

    t_hw(41); go("R3 hw assert 41");
    t_clr(1, 32'h0000_0200); go("R4 clear on hw-pended level 41 no effect");
    t_set(1, 32'h0000_0200); go("R2 sw set on pending 41");
    t_hw(41); go("R3 hw assert removes sw marking");
    t_clr(1, 32'h0000_0200); go("R3 clear ignored after hw assert");

    t_act(41); go("R5 activate level hw-pended stays pending");
    t_deas(41); go("R6 deassert clears level 41");

    t_hw(40); go("R3 hw assert edge 40");
    t_deas(40); go("R6 deassert keeps edge 40");
    t_act(40); go("R5 activate edge 40 clears pending");

    t_set(1, 32'h0000_0400); go("R2 set level 42");
    t_act(42); go("R5 activate sw-pended level 42 clears");

    t_cfg(43, 1, 0); go("R9 cfg 43 edge disabled");
    t_set(1, 32'h0000_0800); go("R2 set 43");
    t_clr(1, 32'h0000_0800); t_hw(43); go("R8 assert beats clear");
    t_clr(1, 32'h0000_0800); t_set(1, 32'h0000_0800); go("R8 set beats clear");

    t_hw(5); go("R7 invalid assert flags error");
    go("R7 error sticky");
    t_act(10); go("R7 invalid activate ignored");
    t_deas(20); t_cfg(3, 1, 1); go("R7 invalid deassert and cfg ignored");
    go("R10 outputs steady");

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule